// File: doc/BRIEF.md
# Windowed Error-Record Countdown Access Unit

This block sits on the system-register path of a processor core. It serves a single system-register encoding that opens a window onto an array of error records. A separate record-select value chooses which record's 64-bit pseudo-fault countdown register the access reaches. Each record also has a two-bit fault-injection capability field, fixed at elaboration.

For each request the block checks the instruction encoding and the current exception level. It then runs a fixed-priority chain of trap checks: the hypervisor fault-injection enable, the hypervisor fine-grained read or write trap, and the monitor fault-injection enable. The result is exactly one of four outcomes: complete, undefined instruction, trap to level 2, or trap to level 3. A trap also carries syndrome class 0x18.

A completed read returns the countdown value in the same cycle. A completed write lands on the next clock edge. If the select is out of range, or the selected record has no injection support, the access is read-as-zero/write-ignored by default. A parameter can turn that case into an undefined outcome instead.

Top module: `err_win_access`

## Requirements
- R1: Only a request whose encoding is op0=0b11, op1=0b000, CRn=0b0101, CRm=0b0100, op2=0b110 gets a response. Any other encoding raises no outcome flag, returns zero data and writes nothing.
- R2: A matching request at exception level 0 (cur_el_i=0) is undefined, whatever the trap controls say.
- R3: At level 1 with level 2 enabled and the hypervisor injection enable at 0, the access traps to level 2. This check outranks every other trap check.
- R4: At level 1 the fine-grained check applies when level 2 is enabled and either level 3 is absent or the monitor fine-grained enable is 1. The check then traps to level 2 if the trap bit for the access direction is set: the read bit for reads, the write bit for writes.
- R5: At level 1 or level 2, with level 3 present and the monitor injection enable at 0, the access traps to level 3. At level 1 this check ranks below R3 and R4. At level 2 the hypervisor and fine-grained controls are ignored.
- R6: A matching request at level 3 always completes, whatever the trap controls say.
- R7: With default parameters (4 records), a completed access with a select of 4 or more reads zero and writes nothing.
- R8: With default parameters, record 2 has capability field 0b00 and records 0, 1 and 3 have non-zero fields. A completed access to record 2 reads zero and writes nothing.
- R9: A completed write to a supported record replaces all 64 bits of its countdown on the next rising edge. A completed read returns the value in the same cycle as the request.
- R10: Each matching request raises exactly one of done, undefined, trap-to-2 and trap-to-3. The syndrome class is 0x18 on a trap and zero otherwise. An access that is not completed writes nothing.
- R11: After reset every countdown reads zero, and with no request valid all outcome flags and data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| enc_op0_i | input | 2 | Encoding op0 |
| enc_op1_i | input | 3 | Encoding op1 |
| enc_crn_i | input | 4 | Encoding CRn |
| enc_crm_i | input | 4 | Encoding CRm |
| enc_op2_i | input | 3 | Encoding op2 |
| req_wdata_i | input | 64 | Write data |
| cur_el_i | input | 2 | Current exception level 0..3 |
| el2_enabled_i | input | 1 | Level 2 enabled in the current state |
| el3_present_i | input | 1 | Level 3 implemented |
| hyp_finj_en_i | input | 1 | Hypervisor fault-injection enable |
| mon_finj_en_i | input | 1 | Monitor fault-injection enable |
| mon_fgt_en_i | input | 1 | Monitor fine-grained trap enable |
| fgt_rd_trap_i | input | 1 | Fine-grained read trap bit for this register |
| fgt_wr_trap_i | input | 1 | Fine-grained write trap bit for this register |
| rec_sel_i | input | SEL_W (8) | Record select |
| rsp_done_o | output | 1 | Access completed |
| rsp_undef_o | output | 1 | Undefined instruction |
| rsp_trap_el2_o | output | 1 | Trap to level 2 |
| rsp_trap_el3_o | output | 1 | Trap to level 3 |
| rsp_ec_o | output | 6 | Syndrome class, valid with a trap |
| rsp_rdata_o | output | 64 | Read data of a completed read |

## Verification
Several trap conditions can hold in the same cycle as a write request. The bench provokes this by setting the hypervisor disable, both fine-grained bits and the monitor disable together. It then checks that only the highest-ranked trap is raised for the request's level. The same cycles also carry write data. A later read at level 3 shows whether the trapped or undefined write reached the record, since such a write must leave it unchanged. A fine-grained bit for the opposite direction is set alongside real accesses, to show that the read and write bits are kept apart.

// File: rtl/err_win_pkg.sv
package err_win_pkg;
  typedef enum logic [1:0] {LVL0 = 2'd0, LVL1 = 2'd1, LVL2 = 2'd2, LVL3 = 2'd3} lvl_e;
  typedef enum logic [2:0] {
    OUT_NONE, OUT_DONE, OUT_UNDEF, OUT_TRAP2, OUT_TRAP3
  } outcome_e;

  localparam logic [1:0] ENC_OP0 = 2'b11;
  localparam logic [2:0] ENC_OP1 = 3'b000;
  localparam logic [3:0] ENC_CRN = 4'b0101;
  localparam logic [3:0] ENC_CRM = 4'b0100;
  localparam logic [2:0] ENC_OP2 = 3'b110;
  localparam logic [5:0] EC_FINJ = 6'h18;
endpackage

// File: rtl/err_win_gate.sv
module err_win_gate
  import err_win_pkg::*;
#(
  parameter bit UNSUP_UNDEF = 1'b0
) (
  input  logic       req_valid_i,
  input  logic       req_write_i,
  input  logic [1:0] op0_i,
  input  logic [2:0] op1_i,
  input  logic [3:0] crn_i,
  input  logic [3:0] crm_i,
  input  logic [2:0] op2_i,
  input  lvl_e       lvl_i,
  input  logic       el2_en_i,
  input  logic       el3_has_i,
  input  logic       hyp_finj_en_i,
  input  logic       mon_finj_en_i,
  input  logic       mon_fgt_en_i,
  input  logic       fgt_rd_i,
  input  logic       fgt_wr_i,
  input  logic       rec_ok_i,
  output logic       hit_o,
  output outcome_e   outcome_o
);
  logic     fgt_bit, hyp_blk, fgt_blk, mon_blk;
  outcome_e grant;

  always_comb begin
    hit_o   = req_valid_i && op0_i == ENC_OP0 && op1_i == ENC_OP1 &&
              crn_i == ENC_CRN && crm_i == ENC_CRM && op2_i == ENC_OP2;
    fgt_bit = req_write_i ? fgt_wr_i : fgt_rd_i;
    hyp_blk = el2_en_i && !hyp_finj_en_i;
    fgt_blk = el2_en_i && (!el3_has_i || mon_fgt_en_i) && fgt_bit;
    mon_blk = el3_has_i && !mon_finj_en_i;
    // unsupported or absent record: RAZ/WI unless configured as undefined
    grant   = (!rec_ok_i && UNSUP_UNDEF) ? OUT_UNDEF : OUT_DONE;
    outcome_o = OUT_NONE;
    if (hit_o) begin
      unique case (lvl_i)
        LVL0: outcome_o = OUT_UNDEF;
        LVL1: begin
          if (hyp_blk)      outcome_o = OUT_TRAP2;
          else if (fgt_blk) outcome_o = OUT_TRAP2;
          else if (mon_blk) outcome_o = OUT_TRAP3;
          else              outcome_o = grant;
        end
        LVL2:    outcome_o = mon_blk ? OUT_TRAP3 : grant;
        default: outcome_o = grant;
      endcase
    end
  end
endmodule

// File: rtl/err_win_bank.sv
module err_win_bank #(
  parameter int unsigned NUM_REC   = 4,
  parameter int unsigned SEL_W     = 8,
  parameter int unsigned REC_STORE = (NUM_REC == 0) ? 1 : NUM_REC,
  parameter logic [2*REC_STORE-1:0] INJ_CAP = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_en_i,
  input  logic [63:0]      wdata_i,
  output logic             rec_ok_o,
  output logic [63:0]      rdata_o
);
  logic [63:0]          cd_q [REC_STORE];
  logic [REC_STORE-1:0] hit_ok;

  for (genvar i = 0; i < REC_STORE; i++) begin : g_rec
    localparam bit LIVE = (i < NUM_REC);
    assign hit_ok[i] = LIVE && (sel_i == SEL_W'(i)) && (INJ_CAP[2*i +: 2] != 2'b00);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   cd_q[i] <= '0;
      else if (wr_en_i && hit_ok[i]) cd_q[i] <= wdata_i;
    end

    a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && hit_ok[i]) |=> cd_q[i] == $past(wdata_i));
    a_r10_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cd_q[i] != $past(cd_q[i])) |-> $past(wr_en_i && hit_ok[i]));
  end

  assign rec_ok_o = |hit_ok;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < REC_STORE; i++)
      if (hit_ok[i]) rdata_o = rdata_o | cd_q[i];
  end
endmodule

// File: rtl/err_win_access.sv
module err_win_access
  import err_win_pkg::*;
#(
  parameter int unsigned NUM_REC     = 4,
  parameter int unsigned SEL_W       = 8,
  parameter bit          UNSUP_UNDEF = 1'b0,
  parameter int unsigned REC_STORE   = (NUM_REC == 0) ? 1 : NUM_REC,
  parameter logic [2*REC_STORE-1:0] INJ_CAP = 8'b01_00_01_10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [1:0]       enc_op0_i,
  input  logic [2:0]       enc_op1_i,
  input  logic [3:0]       enc_crn_i,
  input  logic [3:0]       enc_crm_i,
  input  logic [2:0]       enc_op2_i,
  input  logic [63:0]      req_wdata_i,
  input  logic [1:0]       cur_el_i,
  input  logic             el2_enabled_i,
  input  logic             el3_present_i,
  input  logic             hyp_finj_en_i,
  input  logic             mon_finj_en_i,
  input  logic             mon_fgt_en_i,
  input  logic             fgt_rd_trap_i,
  input  logic             fgt_wr_trap_i,
  input  logic [SEL_W-1:0] rec_sel_i,
  output logic             rsp_done_o,
  output logic             rsp_undef_o,
  output logic             rsp_trap_el2_o,
  output logic             rsp_trap_el3_o,
  output logic [5:0]       rsp_ec_o,
  output logic [63:0]      rsp_rdata_o
);
  outcome_e    outcome;
  logic        hit, rec_ok, wr_en;
  logic [63:0] bank_rdata;

  err_win_gate #(.UNSUP_UNDEF(UNSUP_UNDEF)) u_gate (
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .op0_i        (enc_op0_i),
    .op1_i        (enc_op1_i),
    .crn_i        (enc_crn_i),
    .crm_i        (enc_crm_i),
    .op2_i        (enc_op2_i),
    .lvl_i        (lvl_e'(cur_el_i)),
    .el2_en_i     (el2_enabled_i),
    .el3_has_i    (el3_present_i),
    .hyp_finj_en_i(hyp_finj_en_i),
    .mon_finj_en_i(mon_finj_en_i),
    .mon_fgt_en_i (mon_fgt_en_i),
    .fgt_rd_i     (fgt_rd_trap_i),
    .fgt_wr_i     (fgt_wr_trap_i),
    .rec_ok_i     (rec_ok),
    .hit_o        (hit),
    .outcome_o    (outcome)
  );

  assign wr_en = (outcome == OUT_DONE) && req_write_i;

  err_win_bank #(
    .NUM_REC(NUM_REC), .SEL_W(SEL_W), .REC_STORE(REC_STORE), .INJ_CAP(INJ_CAP)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (rec_sel_i),
    .wr_en_i (wr_en),
    .wdata_i (req_wdata_i),
    .rec_ok_o(rec_ok),
    .rdata_o (bank_rdata)
  );

  assign rsp_done_o     = outcome == OUT_DONE;
  assign rsp_undef_o    = outcome == OUT_UNDEF;
  assign rsp_trap_el2_o = outcome == OUT_TRAP2;
  assign rsp_trap_el3_o = outcome == OUT_TRAP3;
  assign rsp_ec_o       = (rsp_trap_el2_o || rsp_trap_el3_o) ? EC_FINJ : 6'h00;
  assign rsp_rdata_o    = (rsp_done_o && !req_write_i) ? bank_rdata : 64'h0;

  a_r10_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> $countones({rsp_done_o, rsp_undef_o, rsp_trap_el2_o, rsp_trap_el3_o}) == 1);
  a_r1_silent_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> !(rsp_done_o || rsp_undef_o || rsp_trap_el2_o || rsp_trap_el3_o));
  a_r10_ec_on_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ec_o != 6'h00) |-> (rsp_trap_el2_o || rsp_trap_el3_o));
  a_r2_el0_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cur_el_i == 2'd0) |-> rsp_undef_o);
  a_r6_el3_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cur_el_i == 2'd3 && !UNSUP_UNDEF) |-> rsp_done_o);
  a_r3_hyp_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cur_el_i == 2'd1 && el2_enabled_i && !hyp_finj_en_i)
      |-> (rsp_trap_el2_o && rsp_ec_o == 6'h18));
  a_r5_el2_mon: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && cur_el_i == 2'd2 && el3_present_i && !mon_finj_en_i) |-> rsp_trap_el3_o);
endmodule

// File: tb/err_win_access_tb_top.sv
module err_win_access_tb_top;
  typedef struct {
    logic        vld, bad_enc;
    logic [1:0]  el;
    logic        el2, el3, hyp, mon, fgten, fgtr, fgtw;
  } ctl_t;

  typedef struct {
    logic        done, undef, t2, t3;
    logic [5:0]  ec;
    logic [63:0] rdata;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        valid = 0, write = 0;
  logic [1:0]  op0 = 0, cur_el = 0;
  logic [2:0]  op1 = 0, op2 = 0;
  logic [3:0]  crn = 0, crm = 0;
  logic [63:0] wdata = 0;
  logic        el2 = 0, el3 = 0, hyp = 0, mon = 0, fgten = 0, fgtr = 0, fgtw = 0;
  logic [7:0]  sel = 0;
  logic        done, undef, t2, t3;
  logic [5:0]  ec;
  logic [63:0] rdata;

  err_win_access dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .enc_op0_i(op0), .enc_op1_i(op1), .enc_crn_i(crn), .enc_crm_i(crm), .enc_op2_i(op2),
    .req_wdata_i(wdata), .cur_el_i(cur_el), .el2_enabled_i(el2), .el3_present_i(el3),
    .hyp_finj_en_i(hyp), .mon_finj_en_i(mon), .mon_fgt_en_i(fgten),
    .fgt_rd_trap_i(fgtr), .fgt_wr_trap_i(fgtw), .rec_sel_i(sel),
    .rsp_done_o(done), .rsp_undef_o(undef), .rsp_trap_el2_o(t2), .rsp_trap_el3_o(t3),
    .rsp_ec_o(ec), .rsp_rdata_o(rdata)
  );

  int   checks = 0, failures = 0;
  bit   finished = 0;
  exp_t sb_q[$];
  logic [63:0] shadow [4];

  function automatic ctl_t open_ctl(logic [1:0] lvl);
    ctl_t c;
    c.vld = 1; c.bad_enc = 0; c.el = lvl;
    c.el2 = 1; c.el3 = 1; c.hyp = 1; c.mon = 1; c.fgten = 1; c.fgtr = 0; c.fgtw = 0;
    return c;
  endfunction

  function automatic bit rec_ok(logic [7:0] s);
    return s < 8'd4 && s != 8'd2;
  endfunction

  function automatic exp_t predict(ctl_t c, logic wr, logic [7:0] s);
    exp_t e;
    logic fb;
    e.done = 0; e.undef = 0; e.t2 = 0; e.t3 = 0; e.ec = 0; e.rdata = 0; e.tag = "";
    if (!c.vld || c.bad_enc) return e;
    fb = wr ? c.fgtw : c.fgtr;
    case (c.el)
      2'd0: e.undef = 1;
      2'd1: begin
        if (c.el2 && !c.hyp)                         e.t2 = 1;
        else if (c.el2 && (!c.el3 || c.fgten) && fb) e.t2 = 1;
        else if (c.el3 && !c.mon)                    e.t3 = 1;
        else                                         e.done = 1;
      end
      2'd2: if (c.el3 && !c.mon) e.t3 = 1; else e.done = 1;
      default: e.done = 1;
    endcase
    if (e.t2 || e.t3) e.ec = 6'h18;
    if (e.done && !wr && rec_ok(s)) e.rdata = shadow[s[1:0]];
    return e;
  endfunction

  // driver: applies one request per cycle and queues its expected response
  task automatic issue(ctl_t c, logic wr, logic [63:0] wd, logic [7:0] s, string tag);
    exp_t e;
    @(negedge clk);
    valid = c.vld; write = wr; wdata = wd; sel = s; cur_el = c.el;
    op0 = 2'b11; op1 = 3'b000; crn = 4'b0101; crm = c.bad_enc ? 4'b0110 : 4'b0100; op2 = 3'b110;
    el2 = c.el2; el3 = c.el3; hyp = c.hyp; mon = c.mon; fgten = c.fgten; fgtr = c.fgtr; fgtw = c.fgtw;
    e = predict(c, wr, s);
    e.tag = tag;
    sb_q.push_back(e);
    if (e.done && wr && rec_ok(s)) shadow[s[1:0]] = wd;
  endtask

  task automatic readback(logic [7:0] s, string tag);
    issue(open_ctl(2'd3), 1'b0, 64'h0, s, tag);
  endtask

  // monitor: samples mid-cycle and compares against the queue head
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (done !== e.done || undef !== e.undef || t2 !== e.t2 || t3 !== e.t3 ||
            ec !== e.ec || rdata !== e.rdata) begin
          failures++;
          $display("FAIL %s: got done=%b undef=%b t2=%b t3=%b ec=%h rdata=%h exp done=%b undef=%b t2=%b t3=%b ec=%h rdata=%h",
                   e.tag, done, undef, t2, t3, ec, rdata, e.done, e.undef, e.t2, e.t3, e.ec, e.rdata);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ctl_t c;
    for (int i = 0; i < 4; i++) shadow[i] = 64'h0;
    repeat (3) @(posedge clk);
    rst_n = 1;

    // R11: idle outputs and reset contents
    c = open_ctl(2'd3); c.vld = 0;
    issue(c, 1'b0, 64'h0, 8'd0, "R11 idle");
    readback(8'd0, "R11 rec0 reset");
    readback(8'd1, "R11 rec1 reset");
    readback(8'd3, "R11 rec3 reset");

    // R9: full-width write then same-cycle read
    issue(open_ctl(2'd1), 1'b1, 64'hDEAD_BEEF_0123_4567, 8'd0, "R9 write el1");
    issue(open_ctl(2'd2), 1'b0, 64'h0, 8'd0, "R9 read el2");
    issue(open_ctl(2'd3), 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3, "R9 write el3");
    readback(8'd3, "R9 read rec3");
    issue(open_ctl(2'd1), 1'b1, 64'h8000_0000_0000_0001, 8'd1, "R9 write rec1");
    readback(8'd1, "R9 read rec1");

    // R1: wrong encoding is silent and writes nothing
    c = open_ctl(2'd3); c.bad_enc = 1;
    issue(c, 1'b1, 64'h1111, 8'd1, "R1 bad enc write");
    readback(8'd1, "R1 rec1 kept");

    // R2: level 0 undefined even with permissive controls
    issue(open_ctl(2'd0), 1'b0, 64'h0, 8'd0, "R2 el0 read");
    issue(open_ctl(2'd0), 1'b1, 64'h2222, 8'd0, "R2 el0 write");
    readback(8'd0, "R2 rec0 kept");

    // R3: hypervisor disable outranks fine-grained and monitor
    c = open_ctl(2'd1); c.hyp = 0; c.fgtw = 1; c.mon = 0;
    issue(c, 1'b1, 64'h3333, 8'd0, "R3 hyp first");
    readback(8'd0, "R3 rec0 kept");
    c = open_ctl(2'd1); c.el2 = 0; c.hyp = 0; c.fgtr = 1;
    issue(c, 1'b0, 64'h0, 8'd0, "R3 el2 off no trap");

    // R4: direction-selected fine-grained bits
    c = open_ctl(2'd1); c.fgtr = 1; c.mon = 0;
    issue(c, 1'b0, 64'h0, 8'd0, "R4 read bit traps");
    c = open_ctl(2'd1); c.fgtw = 1;
    issue(c, 1'b0, 64'h0, 8'd0, "R4 write bit ignored on read");
    issue(c, 1'b1, 64'h4444, 8'd1, "R4 write bit traps");
    c = open_ctl(2'd1); c.fgtr = 1;
    issue(c, 1'b1, 64'h5555_0000_0000_0055, 8'd1, "R4 read bit ignored on write");
    readback(8'd1, "R4 rec1 value");
    c = open_ctl(2'd1); c.fgten = 0; c.fgtr = 1;
    issue(c, 1'b0, 64'h0, 8'd1, "R4 fgt disabled by monitor");
    c = open_ctl(2'd1); c.el3 = 0; c.fgten = 0; c.fgtr = 1;
    issue(c, 1'b0, 64'h0, 8'd1, "R4 no el3 fgt applies");

    // R5: monitor disable traps to level 3
    c = open_ctl(2'd1); c.mon = 0;
    issue(c, 1'b1, 64'h6666, 8'd3, "R5 el1 mon trap");
    c = open_ctl(2'd2); c.mon = 0; c.hyp = 0; c.fgtr = 1;
    issue(c, 1'b0, 64'h0, 8'd3, "R5 el2 mon trap");
    c = open_ctl(2'd2); c.hyp = 0; c.fgtr = 1;
    issue(c, 1'b0, 64'h0, 8'd3, "R5 el2 ignores hyp");
    c = open_ctl(2'd1); c.el3 = 0; c.mon = 0;
    issue(c, 1'b0, 64'h0, 8'd3, "R5 no el3 no trap");
    readback(8'd3, "R5 rec3 kept");

    // R6: level 3 ignores all traps
    c = open_ctl(2'd3); c.hyp = 0; c.mon = 0; c.fgtr = 1; c.fgtw = 1; c.el2 = 1;
    issue(c, 1'b1, 64'h0123_4567_89AB_CDEF, 8'd3, "R6 el3 write");
    issue(c, 1'b0, 64'h0, 8'd3, "R6 el3 read");

    // R7: out-of-range select is RAZ/WI
    issue(open_ctl(2'd1), 1'b1, 64'h7777, 8'd4, "R7 write sel4");
    issue(open_ctl(2'd1), 1'b0, 64'h0, 8'd4, "R7 read sel4");
    issue(open_ctl(2'd3), 1'b0, 64'h0, 8'd255, "R7 read sel255");
    for (int i = 0; i < 4; i++) readback(8'(i), "R7 records kept");

    // R8: record without injection support is RAZ/WI
    issue(open_ctl(2'd2), 1'b1, 64'h8888, 8'd2, "R8 write rec2");
    readback(8'd2, "R8 rec2 zero");

    c = open_ctl(2'd3); c.vld = 0;
    issue(c, 1'b0, 64'h0, 8'd0, "R10 idle end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule